// File: doc/BRIEF.md
# Spin-Wait Service Call Mailbox

This block is a nine-byte register window at the top of an 8-bit CPU's 16-bit address space. Through it the CPU asks a coprocessor for a service. The CPU writes an operation number to the first byte, and the block raises a busy flag and hands the number to the service side. The service side stores two result bytes and then drops busy. The same window also holds an interrupt enable that gates a latched frame-sync event. Any access to that byte acknowledges the event.

Four bytes of the window always read back fixed instruction codes. With the busy byte and the two result bytes between them, the window forms a small routine. The CPU calls it as a subroutine. A branch-always instruction takes the busy byte as its displacement, so while busy is set it jumps back onto itself. Once busy clears, execution falls through. Two load-immediate instructions then pick up the results, and a return goes back to the caller.

The CPU reads the window combinationally from the address. Side effects happen on the clock edge where a read or write strobe is high.

Top module: `oscall_mailbox`

## Requirements
- R1: After a synchronous active-low reset, busy, interrupt enable, pending event, operation, A and X registers are all zero, and `irq` and `svc_start` are low.
- R2: Offsets 2, 4, 6 and 8 from the window base always read 0x80, 0xA9, 0xA2 and 0x60. CPU writes to these offsets change nothing.
- R3: A CPU write at offset 0 stores the data as the operation number. On that edge busy is set, and `svc_start` goes high for exactly one cycle with `svc_op` equal to the written value.
- R4: Offset 3 reads 0xFE while busy is set and 0x00 when idle. CPU writes to it are ignored.
- R5: `svc_done` clears busy on the next edge. If an operation write arrives on the same edge, busy stays set.
- R6: `svc_a_we` and `svc_x_we` load `svc_wdata` into the A result (read at offset 5) and the X result (read at offset 7). CPU writes to offsets 5 and 7 are ignored.
- R7: A CPU write at offset 1 sets the interrupt enable from data bit 0. Reading offset 1 returns the enable in bit 0, the pending event in bit 7, and zeros elsewhere.
- R8: A `vsync_pulse` sets the pending event only while the enable is set. `irq` is high exactly when enable and pending are both set.
- R9: Any CPU read or write strobe at offset 1 clears the pending event. A `vsync_pulse` on the same edge wins, and the event stays pending.
- R10: Outside the nine-byte window, `cpu_hit` is low, `cpu_rdata` is 0x00, and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe (side effects only) |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data, combinational from address |
| cpu_hit | output | 1 | Address falls inside the window |
| irq | output | 1 | Frame-sync interrupt request |
| vsync_pulse | input | 1 | Frame-sync event, one cycle |
| svc_start | output | 1 | One-cycle pulse: new operation posted |
| svc_op | output | 8 | Posted operation number |
| svc_busy | output | 1 | An operation is outstanding |
| svc_wdata | input | 8 | Result byte from the service side |
| svc_a_we | input | 1 | Load A result |
| svc_x_we | input | 1 | Load X result |
| svc_done | input | 1 | Operation complete, clear busy |

## Verification
All 256 operation numbers are posted in turn, each with distinct A and X results. This separates the operation, A and X paths and catches any swapped or stuck bit. After reset, after writes to every read-only byte, in the busy state and in the idle state, the whole 64K address space is swept and compared with a model. This shows both that the fixed opcode bytes and the busy displacement follow state and that nothing outside the window responds. The interrupt path is driven through the enable-off, enabled, acknowledge-by-read, acknowledge-by-write and event-during-acknowledge cases. The done-versus-start collision shows which one has priority.

// File: rtl/oscall_pkg.sv
`timescale 1ns/1ps
// Shared constants for the service call mailbox: data width, window
// layout (offsets fixed because the CPU executes the window as code) and
// the fixed instruction bytes.
package oscall_pkg;
    localparam int DATA_W    = 8;
    localparam int WIN_BYTES = 9;

    localparam int OFF_OP   = 0;
    localparam int OFF_IRQ  = 1;
    localparam int OFF_BRA  = 2;
    localparam int OFF_BUSY = 3;
    localparam int OFF_LDA  = 4;
    localparam int OFF_A    = 5;
    localparam int OFF_LDX  = 6;
    localparam int OFF_X    = 7;
    localparam int OFF_RTS  = 8;

    localparam logic [DATA_W-1:0] OPC_BRA     = 8'h80;
    localparam logic [DATA_W-1:0] OPC_LDA_IMM = 8'hA9;
    localparam logic [DATA_W-1:0] OPC_LDX_IMM = 8'hA2;
    localparam logic [DATA_W-1:0] OPC_RTS     = 8'h60;
    localparam logic [DATA_W-1:0] SPIN_DISP   = 8'hFE;
    localparam logic [DATA_W-1:0] IDLE_DISP   = 8'h00;

    typedef logic [WIN_BYTES-1:0] slot_sel_t;
    typedef logic [DATA_W-1:0]    byte_t;
endpackage

// File: rtl/oscall_decode.sv
`timescale 1ns/1ps
// Address decoder: one select line per window byte plus a window hit.
// Assumes the window does not wrap past the top of the address space.
module oscall_decode
    import oscall_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'('hFFEF)
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_sel_t         sel,
    output logic              hit
);
    // one comparator per window byte
    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_slot
        assign sel[i] = (addr == BASE_ADDR + ADDR_W'(i));
    end

    assign hit = |sel;
endmodule

// File: rtl/oscall_call_regs.sv
`timescale 1ns/1ps
// Call state: operation number, busy flag, start pulse and the two
// result bytes. A posted operation has priority over completion.
module oscall_call_regs
    import oscall_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  op_wr,
    input  byte_t op_data,
    input  logic  svc_done,
    input  logic  svc_a_we,
    input  logic  svc_x_we,
    input  byte_t svc_wdata,
    output byte_t op_q,
    output logic  busy_q,
    output logic  start_q,
    output byte_t a_q,
    output byte_t x_q
);
    // operation number, busy and start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= op_wr;
            if (op_wr) begin
                op_q   <= op_data;
                busy_q <= 1'b1;
            end else if (svc_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    // result bytes written by the service side only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            x_q <= '0;
        end else begin
            if (svc_a_we) a_q <= svc_wdata;
            if (svc_x_we) x_q <= svc_wdata;
        end
    end
endmodule

// File: rtl/oscall_irq_ctrl.sv
`timescale 1ns/1ps
// Frame-sync interrupt: enable bit, pending latch, acknowledge on any
// access. A new event on the acknowledge edge wins so none is lost.
module oscall_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_access,
    input  logic en_bit,
    input  logic vsync_pulse,
    output logic en_q,
    output logic pend_q,
    output logic irq
);
    // enable and pending state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (cfg_wr) en_q <= en_bit;
            if (vsync_pulse && en_q) pend_q <= 1'b1;
            else if (cfg_access)     pend_q <= 1'b0;
        end
    end

    assign irq = en_q & pend_q;
endmodule

// File: rtl/oscall_mailbox.sv
`timescale 1ns/1ps
// Service call mailbox top. Decodes a nine-byte window, routes CPU
// strobes to the call and interrupt state, and builds the read data,
// including the fixed instruction bytes that make the window a
// self-terminating spin routine. Read data is combinational.
module oscall_mailbox
    import oscall_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'('hFFEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              irq,
    input  logic              vsync_pulse,
    output logic              svc_start,
    output logic [DATA_W-1:0] svc_op,
    output logic              svc_busy,
    input  logic [DATA_W-1:0] svc_wdata,
    input  logic              svc_a_we,
    input  logic              svc_x_we,
    input  logic              svc_done
);
    slot_sel_t sel;
    byte_t     op_q, a_q, x_q;
    logic      busy_q, en_q, pend_q;
    byte_t     slot_val [WIN_BYTES];

    oscall_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr (cpu_addr),
        .sel  (sel),
        .hit  (cpu_hit)
    );

    oscall_call_regs u_call (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_wr     (cpu_wr & sel[OFF_OP]),
        .op_data   (cpu_wdata),
        .svc_done  (svc_done),
        .svc_a_we  (svc_a_we),
        .svc_x_we  (svc_x_we),
        .svc_wdata (svc_wdata),
        .op_q      (op_q),
        .busy_q    (busy_q),
        .start_q   (svc_start),
        .a_q       (a_q),
        .x_q       (x_q)
    );

    oscall_irq_ctrl u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cpu_wr & sel[OFF_IRQ]),
        .cfg_access  ((cpu_wr | cpu_rd) & sel[OFF_IRQ]),
        .en_bit      (cpu_wdata[0]),
        .vsync_pulse (vsync_pulse),
        .en_q        (en_q),
        .pend_q      (pend_q),
        .irq         (irq)
    );

    assign svc_op   = op_q;
    assign svc_busy = busy_q;

    // per-byte read values: state bytes and fixed instruction codes
    always_comb begin
        slot_val[OFF_OP]   = op_q;
        slot_val[OFF_IRQ]  = {pend_q, {(DATA_W-2){1'b0}}, en_q};
        slot_val[OFF_BRA]  = OPC_BRA;
        slot_val[OFF_BUSY] = busy_q ? SPIN_DISP : IDLE_DISP;
        slot_val[OFF_LDA]  = OPC_LDA_IMM;
        slot_val[OFF_A]    = a_q;
        slot_val[OFF_LDX]  = OPC_LDX_IMM;
        slot_val[OFF_X]    = x_q;
        slot_val[OFF_RTS]  = OPC_RTS;
    end

    // one-hot AND-OR read multiplexer, zero outside the window
    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < WIN_BYTES; i++) begin
            cpu_rdata = cpu_rdata | (sel[i] ? slot_val[i] : '0);
        end
    end
endmodule

// File: rtl/oscall_mailbox_checker.sv
`timescale 1ns/1ps
// Protocol checker for oscall_mailbox, observing its ports only.
module oscall_mailbox_checker #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'('hFFEF)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [7:0]        cpu_rdata,
    input logic              cpu_hit,
    input logic              irq,
    input logic              vsync_pulse,
    input logic              svc_start,
    input logic              svc_busy,
    input logic              svc_done
);
    localparam logic [ADDR_W-1:0] A_IRQ  = BASE_ADDR + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_BRA  = BASE_ADDR + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_BUSY = BASE_ADDR + ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_RTS  = BASE_ADDR + ADDR_W'(8);

    a_r3_post_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == BASE_ADDR) |=> (svc_busy && svc_start));

    a_r5_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && !(cpu_wr && cpu_addr == BASE_ADDR)) |=> !svc_busy);

    a_r4_busy_disp: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == A_BUSY) |-> (cpu_rdata == (svc_busy ? 8'hFE : 8'h00)));

    a_r2_branch_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == A_BRA) |-> (cpu_rdata == 8'h80));

    a_r2_return_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == A_RTS) |-> (cpu_rdata == 8'h60));

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && cpu_addr == A_IRQ && !vsync_pulse) |=> !irq);

    a_r8_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(vsync_pulse));

    a_r10_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_hit |-> (cpu_rdata == 8'h00));
endmodule

bind oscall_mailbox oscall_mailbox_checker #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .cpu_rdata   (cpu_rdata),
    .cpu_hit     (cpu_hit),
    .irq         (irq),
    .vsync_pulse (vsync_pulse),
    .svc_start   (svc_start),
    .svc_busy    (svc_busy),
    .svc_done    (svc_done)
);

// File: tb/oscall_mailbox_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a model of the window, full address sweeps, all
// operation numbers, and the interrupt and collision corner cases.
module oscall_mailbox_bench;
    localparam logic [15:0] BASE = 16'hFFEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_hit, irq, svc_start, svc_busy;
    logic        vsync_pulse = 1'b0;
    logic [7:0]  svc_op;
    logic [7:0]  svc_wdata = '0;
    logic        svc_a_we = 1'b0, svc_x_we = 1'b0, svc_done = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model state
    logic [7:0] m_op = '0, m_a = '0, m_x = '0;
    logic       m_busy = 1'b0, m_en = 1'b0, m_pend = 1'b0;

    always #2.5 clk = ~clk;

    oscall_mailbox u_oscall_mailbox (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .cpu_hit(cpu_hit), .irq(irq), .vsync_pulse(vsync_pulse),
        .svc_start(svc_start), .svc_op(svc_op), .svc_busy(svc_busy),
        .svc_wdata(svc_wdata), .svc_a_we(svc_a_we), .svc_x_we(svc_x_we),
        .svc_done(svc_done)
    );

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        case (a)
            BASE:      return m_op;
            BASE + 1:  return {m_pend, 6'b0, m_en};
            BASE + 2:  return 8'h80;
            BASE + 3:  return m_busy ? 8'hFE : 8'h00;
            BASE + 4:  return 8'hA9;
            BASE + 5:  return m_a;
            BASE + 6:  return 8'hA2;
            BASE + 7:  return m_x;
            BASE + 8:  return 8'h60;
            default:   return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // read one byte combinationally and compare with the model
    task automatic rd_chk(input string req, input logic [15:0] a);
        cpu_addr = a;
        #0.01;
        chk(req, {24'b0, cpu_rdata}, {24'b0, exp_read(a)});
    endtask

    // sweep the full address space for data and hit
    task automatic sweep(input string req);
        int bad = 0;
        checks++;
        for (int a = 0; a < 65536; a++) begin
            cpu_addr = a[15:0];
            #0.01;
            if (cpu_rdata !== exp_read(a[15:0]) ||
                cpu_hit !== (a >= BASE && a <= BASE + 8)) begin
                if (bad < 4)
                    $display("FAIL %s: addr %0h actual %0h/%0b expected %0h", req, a,
                             cpu_rdata, cpu_hit, exp_read(a[15:0]));
                bad++;
            end
        end
        if (bad != 0) errors++;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read_strobe(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic svc_load(input bit is_x, input logic [7:0] d);
        @(negedge clk);
        svc_wdata = d;
        if (is_x) svc_x_we = 1'b1; else svc_a_we = 1'b1;
        @(negedge clk);
        svc_a_we = 1'b0; svc_x_we = 1'b0;
    endtask

    task automatic pulse_vsync();
        @(negedge clk);
        vsync_pulse = 1'b1;
        @(negedge clk);
        vsync_pulse = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", svc_busy, 0);
        chk("R1 irq", irq, 0);
        chk("R1 start", svc_start, 0);
        sweep("R1 reset sweep");

        // R2 R4 R6 writes to read-only bytes are ignored
        cpu_write(BASE + 2, 8'hFF);
        cpu_write(BASE + 3, 8'h12);
        cpu_write(BASE + 4, 8'h00);
        cpu_write(BASE + 5, 8'h77);
        cpu_write(BASE + 6, 8'h55);
        cpu_write(BASE + 7, 8'h99);
        cpu_write(BASE + 8, 8'hC3);
        chk("R4 busy untouched", svc_busy, 0);
        sweep("R2 fixed bytes after writes");

        // R10 writes outside the window
        cpu_write(BASE - 1, 8'h5A);
        cpu_write(BASE + 9, 8'h01);
        cpu_write(16'h0000, 8'hA5);
        chk("R10 no busy", svc_busy, 0);
        sweep("R10 outside sweep");

        // R3 R4 R5 R6 every operation number
        for (int op = 0; op < 256; op++) begin
            cpu_write(BASE, op[7:0]);
            m_op = op[7:0]; m_busy = 1'b1;
            chk("R3 start pulse", svc_start, 1);
            chk("R3 op value", svc_op, op);
            chk("R3 busy set", svc_busy, 1);
            rd_chk("R4 spin disp", BASE + 3);
            cpu_write(BASE + 5, 8'h33);
            chk("R3 start single cycle", svc_start, 0);
            svc_load(1'b0, op[7:0] ^ 8'h5A);
            m_a = op[7:0] ^ 8'h5A;
            svc_load(1'b1, ~op[7:0]);
            m_x = ~op[7:0];
            rd_chk("R6 A result", BASE + 5);
            rd_chk("R6 X result", BASE + 7);
            rd_chk("R4 still busy", BASE + 3);
            @(negedge clk); svc_done = 1'b1;
            @(negedge clk); svc_done = 1'b0;
            m_busy = 1'b0;
            chk("R5 busy cleared", svc_busy, 0);
            rd_chk("R4 idle disp", BASE + 3);
            rd_chk("R3 op readback", BASE);
        end
        sweep("R4 idle sweep");

        // R5 post and done on the same edge
        cpu_write(BASE, 8'h42);
        m_op = 8'h42; m_busy = 1'b1;
        @(negedge clk);
        cpu_addr = BASE; cpu_wdata = 8'h43; cpu_wr = 1'b1; svc_done = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; svc_done = 1'b0; m_op = 8'h43;
        chk("R5 start wins", svc_busy, 1);
        sweep("R4 busy sweep");
        @(negedge clk); svc_done = 1'b1;
        @(negedge clk); svc_done = 1'b0; m_busy = 1'b0;
        chk("R5 done alone", svc_busy, 0);

        // R8 event ignored while disabled
        pulse_vsync();
        chk("R8 disabled no irq", irq, 0);
        rd_chk("R8 no pending", BASE + 1);

        // R7 enable and readback
        cpu_write(BASE + 1, 8'hFF);
        m_en = 1'b1;
        rd_chk("R7 enable readback", BASE + 1);
        chk("R8 enable alone no irq", irq, 0);
        pulse_vsync();
        m_pend = 1'b1;
        chk("R8 irq raised", irq, 1);
        rd_chk("R7 pending readback", BASE + 1);

        // R9 acknowledge by read
        cpu_read_strobe(BASE + 1);
        m_pend = 1'b0;
        chk("R9 read ack", irq, 0);
        rd_chk("R9 pending cleared", BASE + 1);

        // R9 acknowledge by write keeping enable
        pulse_vsync();
        m_pend = 1'b1;
        chk("R8 irq again", irq, 1);
        cpu_write(BASE + 1, 8'h01);
        m_pend = 1'b0;
        chk("R9 write ack", irq, 0);

        // R9 event on the acknowledge edge wins
        @(negedge clk);
        cpu_addr = BASE + 1; cpu_rd = 1'b1; vsync_pulse = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0; vsync_pulse = 1'b0; m_pend = 1'b1;
        chk("R9 event wins", irq, 1);

        // R7 R8 disable clears the request
        cpu_write(BASE + 1, 8'hFE);
        m_en = 1'b0; m_pend = 1'b0;
        chk("R8 disabled irq low", irq, 0);
        pulse_vsync();
        chk("R8 disabled event dropped", irq, 0);
        sweep("R7 final sweep");

        // R1 reset restores idle state
        @(negedge clk); rst_n = 1'b0;
        cpu_write(BASE, 8'h11);
        @(negedge clk); rst_n = 1'b1;
        m_op = '0; m_a = '0; m_x = '0; m_busy = 1'b0; m_en = 1'b0; m_pend = 1'b0;
        chk("R1 reset busy", svc_busy, 0);
        sweep("R1 second reset sweep");

        finish_run();
    end
endmodule